// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block is one port of general-purpose pins (32 by default) behind a small word-wide register bus. Software writes a direction mask, an open-drain select mask, an output latch and an input-buffer enable mask. The block drives each pad's output value and output enable from these registers. Pad inputs pass through a two-stage synchronizer before anything inside the block uses them.

A read of the data register returns a per-pin mix. Pins set as outputs report the value held in the output latch. Pins set as inputs report the synchronized pad level, but only if their input buffer is enabled; otherwise they read 0.

Register bits are in reversed order relative to pin numbers: pin n sits at register bit N-1-n. The pad ports are indexed by pin number. The interrupt registers live in a separate block, so their offsets are decoded here as holes.

The bus has no back-pressure. A write takes effect at the clock edge where `bus_we` is high. Read data appears on `bus_rdata` one cycle after the address is presented, and this block never stalls a request.

Top module: `gpio_port`

## Requirements
- R1: After reset, all four registers read 0, every `pad_oe` bit is 0 and every `pad_out` bit is 0.
- R2: The direction register sits at byte offset 0x00. It reads back what was last written there, one cycle after the address is presented.
- R3: Register bit N-1-n controls pin n. When a pin's direction bit is 1 and its open-drain bit is 0, `pad_oe` for that pin is 1 and `pad_out` for that pin equals its output-latch bit.
- R4: The open-drain register sits at offset 0x04. When a pin's open-drain bit is 1, `pad_out` for that pin is 0. If that pin is also an output, `pad_oe` is 1 only while its latch bit is 0, so a latch value of 1 releases the pad.
- R5: A read of the data register at offset 0x08 returns the latch bit for every pin whose direction bit is 1, whatever level is on the pad.
- R6: For an input pin whose input-buffer enable bit is 1, a data read returns the pad level. A pad change shows up in a data read issued two clock edges after the change, and not in a read issued one edge after it.
- R7: For an input pin whose input-buffer enable bit is 0, a data read returns 0 for that bit.
- R8: A write to the data register changes only the output latch. Input pins keep reading their buffered pad level. The latched value appears on the pin once the pin is switched to an output.
- R9: The input-buffer enable register sits at offset 0x18 and reads back what was last written there.
- R10: Offsets 0x0C, 0x10, 0x14, 0x1C and any other offset not decoded here read as 0. Writes to these offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data, registered, one cycle after the address |
| pad_in | input | N | Pad input levels, indexed by pin |
| pad_out | output | N | Pad drive values, indexed by pin |
| pad_oe | output | N | Pad output enables, indexed by pin |

## Verification
The bench uses asymmetric direction masks so that a design without the bit reversal would enable the wrong pads. It holds the pads at the opposite level from the latch, so a design that reads the pad instead of the latch for output pins fails the check. It changes a pad and reads once one edge later and once two edges later; a design with too few or too many synchronizer stages returns the wrong value in one of those two reads. It also writes ones to the latch of input pins and writes patterns to the interrupt-hole offsets. A design that lets the latch leak into input readback, or that aliases a hole onto a real register, returns nonzero or corrupted data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFF_DIR  = 8'h00;
  localparam logic [7:0] OFF_ODS  = 8'h04;
  localparam logic [7:0] OFF_DATA = 8'h08;
  localparam logic [7:0] OFF_IBE  = 8'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_ODS,
    SEL_DATA,
    SEL_IBE
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

  // Latency check, valid once two edges have passed since reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;

  generate
    if (STAGES == 2) begin : g_chk
      assert_sync_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output reg_sel_e          sel_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      ods_o,
  output logic [N-1:0]      lat_o,
  output logic [N-1:0]      ibe_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_DIR))  sel_o = SEL_DIR;
    else if (addr_i == ADDR_W'(OFF_ODS))  sel_o = SEL_ODS;
    else if (addr_i == ADDR_W'(OFF_DATA)) sel_o = SEL_DATA;
    else if (addr_i == ADDR_W'(OFF_IBE))  sel_o = SEL_IBE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o <= '0;
      ods_o <= '0;
      lat_o <= '0;
      ibe_o <= '0;
    end else if (we_i) begin
      unique case (sel_o)
        SEL_DIR:  dir_o <= wdata_i;
        SEL_ODS:  ods_o <= wdata_i;
        SEL_DATA: lat_o <= wdata_i;
        SEL_IBE:  ibe_o <= wdata_i;
        default:  ;
      endcase
    end
  end

  assert_dir_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_W'(OFF_DIR)) |=> (dir_o == $past(wdata_i)));

  assert_hole_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_o == SEL_NONE) |=>
      ($stable(dir_o) && $stable(ods_o) && $stable(lat_o) && $stable(ibe_o)));
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int N = 32
) (
  input  logic [N-1:0] dir_l_i,
  input  logic [N-1:0] ods_l_i,
  input  logic [N-1:0] lat_l_i,
  output logic [N-1:0] pad_out_o,
  output logic [N-1:0] pad_oe_o
);
  genvar n;
  generate
    for (n = 0; n < N; n++) begin : g_pin
      always_comb begin
        if (ods_l_i[n]) begin
          pad_out_o[n] = 1'b0;
          pad_oe_o[n]  = dir_l_i[n] & ~lat_l_i[n];
        end else begin
          pad_out_o[n] = lat_l_i[n];
          pad_oe_o[n]  = dir_l_i[n];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pad_in,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe
);
  localparam int MSB = N - 1;

  reg_sel_e     sel;
  logic [N-1:0] dir_r, ods_r, lat_r, ibe_r;
  logic [N-1:0] dir_l, ods_l, lat_l;
  logic [N-1:0] pin_sync_l, pin_sync_r;
  logic [N-1:0] data_view, rd_mux;

  gpio_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .sel_o(sel),
    .dir_o(dir_r), .ods_o(ods_r), .lat_o(lat_r), .ibe_o(ibe_r)
  );

  gpio_sync #(.W(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_in), .q_o(pin_sync_l)
  );

  // Pin n <-> register bit MSB-n.
  genvar n;
  generate
    for (n = 0; n < N; n++) begin : g_map
      assign dir_l[n]           = dir_r[MSB-n];
      assign ods_l[n]           = ods_r[MSB-n];
      assign lat_l[n]           = lat_r[MSB-n];
      assign pin_sync_r[MSB-n]  = pin_sync_l[n];
    end
  endgenerate

  gpio_pad_drv #(.N(N)) u_pad (
    .dir_l_i(dir_l), .ods_l_i(ods_l), .lat_l_i(lat_l),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  assign data_view = (pin_sync_r & ibe_r & ~dir_r) | (lat_r & dir_r);

  always_comb begin
    unique case (sel)
      SEL_DIR:  rd_mux = dir_r;
      SEL_ODS:  rd_mux = ods_r;
      SEL_DATA: rd_mux = data_view;
      SEL_IBE:  rd_mux = ibe_r;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;

  assert_oe_needs_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_l) == '0));

  assert_od_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ods_l & lat_l) == '0 && (pad_out & ods_l) == '0));

  assert_rd_ibe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |=>
      ((bus_rdata & ~$past(dir_r) & ~$past(ibe_r)) == '0));

  assert_rd_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |=>
      ((bus_rdata & $past(dir_r)) == ($past(lat_r) & $past(dir_r))));
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int N  = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata, pin, pout, poe;
  initial pin = '0;

  gpio_port #(.N(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pin),
    .pad_out(pout), .pad_oe(poe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [AW-1:0] a;
    logic [N-1:0]  exp;
    int            due;
    string         tag;
  } rd_item_t;
  rd_item_t sbq[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Monitor: pops reads whose data is due and compares.
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        rd_item_t it;
        it = sbq.pop_front();
        check($sformatf("%s rd@%h", it.tag, it.a), rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [N-1:0] exp, string tag);
    rd_item_t it;
    @(negedge clk);
    addr = a; we = 1'b0;
    it.a = a; it.exp = exp; it.due = cyc + 1; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 pad_oe", poe, '0);
    check("R1 pad_out", pout, '0);
    rd(8'h00, '0, "R1");
    rd(8'h04, '0, "R1");
    rd(8'h08, '0, "R1");
    rd(8'h18, '0, "R1");

    // R2: direction readback; R3: bit reversal on pad_oe
    wr(8'h00, 32'h8000_0003);
    rd(8'h00, 32'h8000_0003, "R2");
    check("R3 pad_oe reversed", poe, 32'hC000_0001);

    // R3: latch drives pad_out (pins 0..15 = reg bits 31..16)
    wr(8'h08, 32'hFFFF_0000);
    check("R3 pad_out", pout, 32'h0000_FFFF);
    check("R3 pad_oe push-pull", poe, 32'hC000_0001);

    // R5/R7: pads high, buffers off: outputs report latch, inputs 0
    @(negedge clk); pin = '1;
    repeat (3) @(negedge clk);
    rd(8'h08, 32'h8000_0000, "R5 R7");

    // R9 / R6: enable buffers on reg bits 15..0
    wr(8'h18, 32'h0000_FFFF);
    rd(8'h18, 32'h0000_FFFF, "R9");
    rd(8'h08, 32'h8000_FFFC, "R6");

    // R6 latency: pad drops; one edge later old value, two edges later new
    @(negedge clk); pin = '0;
    rd(8'h08, 32'h8000_FFFC, "R6 one-edge");
    rd(8'h08, 32'h8000_0000, "R6 two-edge");

    // R8: data write reaches only outputs; inputs keep pad level
    wr(8'h08, 32'h0000_00FF);
    rd(8'h08, 32'h0000_0003, "R8 inputs ignore");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_00FF, "R8 latch appears");
    check("R3 pad_out all out", pout, 32'hFF00_0000);

    // R4: open-drain everywhere: latch 1 releases pins 24..31
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'hFFFF_FFFF, "R4");
    check("R4 pad_oe", poe, 32'h00FF_FFFF);
    check("R4 pad_out", pout, 32'h0000_0000);

    // R10: holes read 0, writes land nowhere
    wr(8'h0C, 32'hA5A5_A5A5);
    wr(8'h10, 32'hA5A5_A5A5);
    wr(8'h14, 32'hA5A5_A5A5);
    wr(8'h1C, 32'hA5A5_A5A5);
    rd(8'h0C, '0, "R10");
    rd(8'h10, '0, "R10");
    rd(8'h14, '0, "R10");
    rd(8'h1C, '0, "R10");
    rd(8'h00, 32'hFFFF_FFFF, "R10 dir kept");
    rd(8'h08, 32'h0000_00FF, "R10 latch kept");
    rd(8'h18, 32'h0000_FFFF, "R10 ibe kept");
    check("R10 pad_oe kept", poe, 32'h00FF_FFFF);

    drain();
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard left=%0d expected=0", sbq.size());
    end
    finish_run();
  end
endmodule